// File: doc/BRIEF.md
# Processor Status Register with Sense Inputs and Serial Shifter

This block holds the flag and control state of a small processor core and the shift register it uses for bit-serial I/O. It drives three general-purpose flag pins and an interrupt-enable bit. It also samples two external condition pins through a synchronizer. The core changes the flags and the enable bit by copying its accumulator into the status register. It tests the condition pins by reading the status register back into the accumulator.

The first condition pin, A, also serves as a level-sensitive interrupt request. It does so only while interrupt enable is set. The second pin, B, is always a plain testable condition.

A serial-shift command moves the shift register one place toward bit 0 and loads the serial input pin into the top bit. The bit that falls out of bit 0 goes to the serial output pin. That pin keeps its value until the next shift command.

Top module: `stat_sio_unit`

## Requirements
- R1: While reset is held and after it is released, the flags, interrupt enable, serial output pin, shift register and interrupt request all read 0.
- R2: A status write (`stat_wr_i` high at a clock edge) loads `acc_i[2:0]` into the flag outputs and `acc_i[3]` into interrupt enable. Both are visible after that edge.
- R3: On a status write, `acc_i[7:4]` has no effect. Status read bits 7 and 6 always read 0.
- R4: Status read bit 4 shows condition pin A and bit 5 shows pin B. Each passes through two flops: a change becomes visible after the second clock edge and not after the first.
- R5: `irq_o` is high exactly when the synchronized pin A is high and interrupt enable is set. Pin B never raises `irq_o`.
- R6: On a shift command, the shift register becomes `{ser_in_i, reg[7:1]}` and the serial output pin takes the old `reg[0]`.
- R7: Without a shift command, the serial output pin and the shift register keep their values.
- R8: Without a status write, the flags and interrupt enable keep their values.
- R9: With interrupt enable clear, pin A is still readable in status bit 4 while `irq_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| sense_a_i | input | 1 | Condition pin A, asynchronous; interrupt request when enabled |
| sense_b_i | input | 1 | Condition pin B, asynchronous |
| acc_i | input | 8 | Accumulator value for a status write |
| stat_wr_i | input | 1 | Copy accumulator into status register |
| stat_rd_o | output | 8 | Status register value for a copy into the accumulator |
| shift_i | input | 1 | Serial-shift command |
| ser_in_i | input | 1 | Serial data in |
| ser_out_o | output | 1 | Latched serial data out |
| shift_reg_o | output | 8 | Shift register contents |
| flags_o | output | 3 | General-purpose flag pins |
| irq_o | output | 1 | Level interrupt request |

## Verification
The status write is swept over all 256 accumulator values. This separates the flag bits and the enable bit from the high bits that must be dropped.

All four combinations of the two condition pins are applied with the enable bit both set and clear. This shows which pin feeds the interrupt and how the enable gates it. A sampling point taken one edge early tells the two-flop latency apart from a one-flop path.

An irregular serial bit stream is shifted in, with idle cycles inserted. This shows the shift direction, the fill bit and the hold of the output pin between shifts.

// File: rtl/stat_sio_pkg.sv
package stat_sio_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned FLAG_N = 3;
  localparam int unsigned IE_POS = FLAG_N;
  localparam int unsigned SA_POS = IE_POS + 1;
  localparam int unsigned SB_POS = SA_POS + 1;
endpackage

// File: rtl/rst_release.sv
module rst_release #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_q
);
  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[DEPTH-2:0], 1'b1};
  end

  assign rst_n_q = chain_q[DEPTH-1];
endmodule

// File: rtl/sense_sync.sv
module sense_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/status_reg.sv
module status_reg
  import stat_sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IE_POS:0]   wr_data,
  input  logic              sense_a,
  input  logic              sense_b,
  output logic [FLAG_N-1:0] flags,
  output logic              ie,
  output logic [STAT_W-1:0] stat_rd
);
  logic [FLAG_N-1:0] flags_d;
  logic              ie_d;

  always_comb begin
    flags_d = flags;
    ie_d    = ie;
    if (wr_en) begin
      flags_d = wr_data[FLAG_N-1:0];
      ie_d    = wr_data[IE_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      ie    <= 1'b0;
    end else begin
      flags <= flags_d;
      ie    <= ie_d;
    end
  end

  always_comb begin
    stat_rd                 = '0;
    stat_rd[FLAG_N-1:0]     = flags;
    stat_rd[IE_POS]         = ie;
    stat_rd[SA_POS]         = sense_a;
    stat_rd[SB_POS]         = sense_b;
  end

  // R2: a write lands in the flags one edge later
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (flags == $past(wr_data[FLAG_N-1:0])) && (ie == $past(wr_data[IE_POS])));
  // R8: no write, no change
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(flags) && $stable(ie));
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic             ser_out,
  output logic [WIDTH-1:0] data_q
);
  logic [WIDTH-1:0] data_d;
  logic             ser_out_d;

  always_comb begin
    data_d    = data_q;
    ser_out_d = ser_out;
    if (shift_en) begin
      data_d    = {ser_in, data_q[WIDTH-1:1]};
      ser_out_d = data_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      ser_out <= 1'b0;
    end else begin
      data_q  <= data_d;
      ser_out <= ser_out_d;
    end
  end

  // R6: the dropped bit appears on the pin, the input bit enters at the top
  p_shift_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (ser_out == $past(data_q[0])) && (data_q[WIDTH-1] == $past(ser_in)));
  // R7: pin is latched between shifts
  p_pin_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(ser_out) && $stable(data_q));
endmodule

// File: rtl/stat_sio_unit.sv
module stat_sio_unit
  import stat_sio_pkg::*;
#(
  parameter int unsigned SHIFT_W     = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sense_a_i,
  input  logic               sense_b_i,
  input  logic [STAT_W-1:0]  acc_i,
  input  logic               stat_wr_i,
  output logic [STAT_W-1:0]  stat_rd_o,
  input  logic               shift_i,
  input  logic               ser_in_i,
  output logic               ser_out_o,
  output logic [SHIFT_W-1:0] shift_reg_o,
  output logic [FLAG_N-1:0]  flags_o,
  output logic               irq_o
);
  logic       rst_n_int;
  logic [1:0] sense_raw;
  logic [1:0] sense_s;
  logic       ie;
  logic       unused_acc_hi;

  assign unused_acc_hi = ^acc_i[STAT_W-1:IE_POS+1];
  assign sense_raw     = {sense_b_i, sense_a_i};

  rst_release #(.DEPTH(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_q(rst_n_int)
  );

  sense_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .async_i(sense_raw), .sync_o(sense_s)
  );

  status_reg u_stat (
    .clk(clk), .rst_n(rst_n_int), .wr_en(stat_wr_i),
    .wr_data(acc_i[IE_POS:0]), .sense_a(sense_s[0]), .sense_b(sense_s[1]),
    .flags(flags_o), .ie(ie), .stat_rd(stat_rd_o)
  );

  serial_shifter #(.WIDTH(SHIFT_W)) u_shift (
    .clk(clk), .rst_n(rst_n_int), .shift_en(shift_i), .ser_in(ser_in_i),
    .ser_out(ser_out_o), .data_q(shift_reg_o)
  );

  assign irq_o = sense_s[0] & ie;

  // R5: the request follows the read-back A bit gated by the read-back enable
  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq_o == (stat_rd_o[SA_POS] && stat_rd_o[IE_POS]));
  // R3: reserved bits never set
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    stat_rd_o[STAT_W-1:SB_POS+1] == '0);
endmodule

// File: tb/test_stat_sio_unit.sv
module test_stat_sio_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sense_a_i, sense_b_i, stat_wr_i, shift_i, ser_in_i;
  logic [7:0] acc_i;
  logic [7:0] stat_rd_o;
  logic       ser_out_o;
  logic [7:0] shift_reg_o;
  logic [2:0] flags_o;
  logic       irq_o;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  stat_sio_unit i_stat_sio_unit (
    .clk(clk), .rst_n(rst_n), .sense_a_i(sense_a_i), .sense_b_i(sense_b_i),
    .acc_i(acc_i), .stat_wr_i(stat_wr_i), .stat_rd_o(stat_rd_o),
    .shift_i(shift_i), .ser_in_i(ser_in_i), .ser_out_o(ser_out_o),
    .shift_reg_o(shift_reg_o), .flags_o(flags_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] e_m;
    logic       so_m;
    logic [2:0] fl_m;
    rst_n = 0; sense_a_i = 0; sense_b_i = 0; stat_wr_i = 0; shift_i = 0;
    ser_in_i = 0; acc_i = 0;
    repeat (3) @(negedge clk);
    check("R1 flags in reset", {5'd0, flags_o}, 8'd0);
    check("R1 irq in reset", {7'd0, irq_o}, 8'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 status", stat_rd_o, 8'd0);
    check("R1 shift reg", shift_reg_o, 8'd0);
    check("R1 ser out", {7'd0, ser_out_o}, 8'd0);
    check("R1 irq", {7'd0, irq_o}, 8'd0);

    // R2 R3: exhaustive accumulator sweep
    for (int v = 0; v < 256; v++) begin
      acc_i = 8'(v); stat_wr_i = 1;
      @(negedge clk);
      check("R2 flags", {5'd0, flags_o}, 8'(v & 7));
      check("R3 status read", stat_rd_o, 8'(v & 8'h0F));
    end
    // R8: no write, hold
    fl_m = flags_o;
    stat_wr_i = 0; acc_i = 8'h00;
    repeat (3) @(negedge clk);
    check("R8 flags hold", {5'd0, flags_o}, {5'd0, fl_m});
    check("R8 ie hold", {7'd0, stat_rd_o[3]}, 8'd1);

    // R4 R5 R9: sense combos x enable
    for (int ie = 0; ie < 2; ie++) begin
      for (int sc = 0; sc < 4; sc++) begin
        acc_i = 8'(ie << 3); stat_wr_i = 1;
        sense_a_i = sc[0]; sense_b_i = sc[1];
        @(negedge clk);
        stat_wr_i = 0;
        @(negedge clk);
        check("R4 sense bits", {6'd0, stat_rd_o[5:4]}, 8'(sc));
        check("R5 irq", {7'd0, irq_o}, 8'(ie & sc & 1));
        if (ie == 0) check("R9 A readable", {7'd0, stat_rd_o[4]}, 8'(sc & 1));
      end
    end
    // R4 latency: one edge is not enough
    sense_a_i = 0; sense_b_i = 0;
    repeat (3) @(negedge clk);
    sense_a_i = 1; sense_b_i = 1;
    @(negedge clk);
    check("R4 one edge early", {6'd0, stat_rd_o[5:4]}, 8'd0);
    @(negedge clk);
    check("R4 second edge", {6'd0, stat_rd_o[5:4]}, 8'd3);
    sense_a_i = 0; sense_b_i = 0;

    // R6 R7: serial stream
    e_m = shift_reg_o; so_m = ser_out_o;
    for (int i = 0; i < 48; i++) begin
      logic b;
      b = 1'(((i * 13) ^ (i >> 2)) & 1);
      ser_in_i = b;
      shift_i = (i % 5 != 4);
      @(negedge clk);
      if (i % 5 != 4) begin
        so_m = e_m[0];
        e_m  = {b, e_m[7:1]};
        check("R6 shift reg", shift_reg_o, e_m);
        check("R6 ser out", {7'd0, ser_out_o}, {7'd0, so_m});
      end else begin
        check("R7 shift reg hold", shift_reg_o, e_m);
        check("R7 ser out hold", {7'd0, ser_out_o}, {7'd0, so_m});
      end
    end
    shift_i = 0;
    repeat (2) @(negedge clk);
    check("R7 idle", {7'd0, ser_out_o}, {7'd0, so_m});
    finish_run();
  end
endmodule